// File: doc/BRIEF.md
# Periodic Actuator Self-Calibration Scheduler

This block tells the drive controller when to run actuator self-calibration. The first request comes straight out of reset, before any host activity. After that, each request follows the completion of the previous calibration by an interval taken from a parameter table. The table is counted in prescaled ticks, and its defaults give gaps of about 5, 5, 10 and 10 minutes. Once the table is used up, the last interval repeats for as long as the block runs.

A deadline that expires while the controller is executing a host command does not interrupt that command. The request is held internally and appears on the first cycle on which the busy flag is low. A request stays up until the calibration engine pulses done. The next interval is counted from that pulse.

The step output gives the index of the calibration currently awaited or requested. The complete flag shows that every entry of the table has been served.

Top module: `cal_sched`

## Requirements
- R1: After reset (power-on or asynchronous `rst_ni` low), `step_o` is 0, `sched_done_o` is 0 and a request is pending, so `cal_req_o` is high whenever `busy_i` is low.
- R2: While `busy_i` is high, `cal_req_o` is low even if a request is pending. The held request shows on `cal_req_o` in the same cycle that `busy_i` returns low.
- R3: A `cal_done_i` pulse sampled while a request is pending clears the request and advances `step_o` by one, up to a ceiling of N_INT.
- R4: After a served request, `cal_req_o` rises right after the clock edge that samples the L-th high `tick_i`, where L is the interval for the new step. Cycles with `tick_i` low do not count.
- R5: The interval before step s (1 ≤ s ≤ N_INT) is table entry s-1. Entry i occupies bits [i*CNT_W +: CNT_W] of INTERVALS, so the schedule need not be uniform.
- R6: Once `step_o` has reached N_INT, every further served request keeps `step_o` at N_INT and waits for the final table entry again.
- R7: `sched_done_o` rises on the done pulse that serves step N_INT and stays high until reset.
- R8: A `cal_done_i` pulse with no request pending is ignored. It does not change `step_o` and does not restart the running interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled timebase tick, one cycle wide |
| busy_i | input | 1 | High while a host command executes |
| cal_done_i | input | 1 | One-cycle pulse when a calibration finishes |
| cal_req_o | output | 1 | Calibration request to the controller |
| step_o | output | STEP_W | Index of the current schedule step |
| sched_done_o | output | 1 | Every table step has been served |

## Verification
A step register that advances wrongly shows up first at the next request. The request arrives after the wrong table entry's tick count, so with the shrunk bench table the error is visible within a few ticks. A pending flag that is lost or set twice shows at once on `cal_req_o`: a request goes missing while the controller is idle, or one appears while the interval timer is still counting. A timer restarted by a stray done pulse delays the next request by whole ticks, and the bench detects this by counting ticks up to the edge where the request rises.

// File: rtl/cal_sched_pkg.sv
package cal_sched_pkg;
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction
endpackage

// File: rtl/cal_interval_timer.sv
module cal_interval_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             tick_i,
  output logic             expire_o,
  output logic             armed_o
);
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             armed_q;

  assign expire_o = armed_q & tick_i & (cnt_q == lim_q - 1'b1);
  assign armed_o  = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      lim_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= '0;
      lim_q   <= (limit_i == '0) ? CNT_W'(1) : limit_i;
      armed_q <= 1'b1;
    end else if (armed_q && tick_i) begin
      if (expire_o) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: count never reaches the latched limit while armed
  p_cnt_below_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (cnt_q < lim_q));
  // R4: no tick, no progress
  p_hold_without_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !tick_i && !start_i) |=> ($stable(cnt_q) && armed_q));
endmodule

// File: rtl/cal_step_track.sv
module cal_step_track
  import cal_sched_pkg::*;
#(
  parameter int N_INT  = 4,
  parameter int STEP_W = $clog2(N_INT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [STEP_W-1:0] step_o,
  output logic [STEP_W-1:0] next_step_o,
  output logic              complete_o
);
  logic [STEP_W-1:0] step_q;
  logic              complete_q;

  assign next_step_o = STEP_W'(sat_inc(int'(step_q), N_INT));
  assign step_o      = step_q;
  assign complete_o  = complete_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q     <= '0;
      complete_q <= 1'b0;
    end else if (adv_i) begin
      step_q     <= next_step_o;
      complete_q <= complete_q | (int'(step_q) == N_INT);
    end
  end

  p_step_monotonic_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (step_q >= $past(step_q)));
  p_step_needs_adv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(step_q));
  p_step_ceiling_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && int'(step_q) == N_INT) |=> (int'(step_q) == N_INT));
  p_complete_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_q |=> complete_q);
endmodule

// File: rtl/cal_sched.sv
module cal_sched #(
  parameter int                     N_INT     = 4,
  parameter int                     CNT_W     = 32,
  parameter logic [N_INT*CNT_W-1:0] INTERVALS = {32'd600, 32'd600, 32'd300, 32'd300},
  localparam int                    STEP_W    = $clog2(N_INT + 1),
  localparam int                    IDX_W     = (N_INT > 1) ? $clog2(N_INT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              busy_i,
  input  logic              cal_done_i,
  output logic              cal_req_o,
  output logic [STEP_W-1:0] step_o,
  output logic              sched_done_o
);
  logic [CNT_W-1:0]  tbl [N_INT];
  logic [STEP_W-1:0] next_step;
  logic [IDX_W-1:0]  idx;
  logic              pending_q, serve, expire, armed;

  for (genvar g = 0; g < N_INT; g++) begin : g_tbl
    assign tbl[g] = INTERVALS[g*CNT_W +: CNT_W];
  end

  assign serve     = cal_done_i & pending_q;
  assign idx       = IDX_W'(next_step - 1'b1);
  assign cal_req_o = pending_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pending_q <= 1'b1;
    else if (serve)  pending_q <= 1'b0;
    else if (expire) pending_q <= 1'b1;
  end

  cal_step_track #(.N_INT(N_INT), .STEP_W(STEP_W)) u_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (serve),
    .step_o      (step_o),
    .next_step_o (next_step),
    .complete_o  (sched_done_o)
  );

  cal_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (serve),
    .limit_i  (tbl[idx]),
    .tick_i   (tick_i),
    .expire_o (expire),
    .armed_o  (armed)
  );

  p_req_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !cal_done_i) |=> pending_q);
  p_req_excl_timer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_req_o |-> !armed);
  p_serve_arms_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serve |=> (armed && !pending_q));
  p_busy_masks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !cal_req_o);
endmodule

// File: tb/cal_sched_test.sv
module cal_sched_test;
  localparam int N_INT = 4;
  localparam int CNT_W = 8;

  logic clk_i = 0, rst_ni = 0, tick_i = 0, busy_i = 0, cal_done_i = 0;
  logic       cal_req_o, sched_done_o;
  logic [2:0] step_o;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  cal_sched #(.N_INT(N_INT), .CNT_W(CNT_W),
              .INTERVALS({8'd6, 8'd6, 8'd3, 8'd3})) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .busy_i(busy_i),
    .cal_done_i(cal_done_i), .cal_req_o(cal_req_o), .step_o(step_o),
    .sched_done_o(sched_done_o));

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic d);
    tick_i = t; cal_done_i = d;
    @(posedge clk_i); #1;
    tick_i = 0; cal_done_i = 0;
  endtask

  // n ticks, each followed by an idle cycle; request must rise exactly on the last
  task automatic run_interval(input string r, input int n);
    for (int i = 1; i <= n; i++) begin
      cyc(1, 0);
      if (i < n) check({r, " early req"}, cal_req_o, 0);
      cyc(0, 0);
    end
    check({r, " req after interval"}, cal_req_o, 1);
  endtask

  task automatic t_reset;
    rst_ni = 0; #7; rst_ni = 1;
    @(posedge clk_i); #1;
    check("R1 req", cal_req_o, 1);
    check("R1 step", step_o, 0);
    check("R1 done flag", sched_done_o, 0);
  endtask

  task automatic t_busy_hold;
    busy_i = 1; #1;
    check("R2 masked", cal_req_o, 0);
    cyc(1, 0); cyc(1, 0);
    check("R2 still masked", cal_req_o, 0);
    busy_i = 0; #1;
    check("R2 released", cal_req_o, 1);
  endtask

  task automatic t_serve_first;
    cyc(0, 1);
    check("R3 req cleared", cal_req_o, 0);
    check("R3 step", step_o, 1);
    run_interval("R4 step1", 3);
  endtask

  task automatic t_stray_done;
    cyc(0, 1);                      // serve step 1
    check("R3 step2", step_o, 2);
    cyc(1, 0);                      // tick 1 of 3
    cyc(0, 1);                      // stray done, nothing pending
    check("R8 step unchanged", step_o, 2);
    check("R8 no req", cal_req_o, 0);
    cyc(1, 0);
    check("R8 no req 2", cal_req_o, 0);
    busy_i = 1;
    cyc(1, 0);                      // tick 3: expires under busy
    check("R8 no restart / R2 masked", cal_req_o, 0);
    busy_i = 0; #1;
    check("R2 pending shown idle", cal_req_o, 1);
  endtask

  task automatic t_long_steps;
    cyc(0, 1);
    check("R5 step3", step_o, 3);
    run_interval("R5 step3", 6);
    cyc(0, 1);
    check("R5 step4", step_o, 4);
    check("R7 not yet", sched_done_o, 0);
    run_interval("R5 step4", 6);
  endtask

  task automatic t_repeat;
    cyc(0, 1);
    check("R6 step saturates", step_o, 4);
    check("R7 complete", sched_done_o, 1);
    run_interval("R6 repeat", 6);
    cyc(0, 1);
    check("R6 step still", step_o, 4);
    check("R7 sticky", sched_done_o, 1);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_busy_hold();
    t_serve_first();
    t_stray_done();
    t_long_steps();
    t_repeat();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule